// File: doc/BRIEF.md
# Serial Bit-Rate Prescaler

This block turns the system clock into the two timing strobes a serial port needs. One is an oversample strobe for the receiver. The other is a bit-period strobe for the transmitter. The divide value is a 12-bit number N, held as an upper part and a lower part in two byte-wide registers. The oversample strobe repeats every N+1 clock cycles. The bit strobe divides the oversample strobe by 16 in normal mode, or by 8 when the double-speed input is high. The bit rate is therefore fclk/(16·(N+1)) in normal mode and fclk/(8·(N+1)) in double-speed mode.

Software loads the divisor one byte at a time. Writing the upper byte only stages the new upper bits. Writing the lower byte reloads the down-counter at once with the full 12-bit value and restarts the bit phase. Between writes, the counter reloads from the stored divisor each time it reaches zero. The block does not protect frames already in flight when the divisor changes.

Top module: `baud_prescaler`

## Requirements
- R1: After a synchronous active-low reset, both strobes are low and both readback bytes read zero.
- R2: The upper readback byte returns the stored divisor bits 11:8 in bits 3:0. Bits 7:4 always read zero, whatever value was written to them.
- R3: A lower-byte write loads the counter with {upper bits, written byte} at that clock edge. Neither strobe is high in the cycle that follows. The next oversample strobe comes N+1 cycles after the write edge.
- R4: With no writes, the oversample strobe is high for exactly one cycle in every N+1 cycles.
- R5: An upper-byte write on its own does not disturb the count in progress. The new upper bits take effect at the next natural reload.
- R6: In normal mode (double-speed low), the bit strobe is high for one cycle every 16·(N+1) cycles. It rises the cycle after the 16th oversample strobe that follows a lower-byte write.
- R7: In double-speed mode, the bit strobe is high for one cycle every 8·(N+1) cycles. It rises the cycle after the 8th oversample strobe.
- R8: With N=0, the oversample strobe is high every cycle, and the bit strobe repeats every 16 or 8 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_we | input | 1 | Write strobe for the upper divisor byte |
| lo_we | input | 1 | Write strobe for the lower divisor byte (reloads the counter) |
| wdata | input | 8 | Write data for either byte |
| dbl_speed | input | 1 | 1 = divide the oversample strobe by 8, 0 = by 16 |
| hi_rdata | output | 8 | Upper divisor byte readback, bits 7:4 zero |
| lo_rdata | output | 8 | Lower divisor byte readback |
| os_tick | output | 1 | Oversample strobe, one cycle wide |
| bit_tick | output | 1 | Bit-period strobe, one cycle wide |

## Verification
The bench builds the block with its default 12-bit divisor and oversample factor 16. In both modes it sweeps every divisor from 0 to 15, and it adds one divisor that uses the upper byte. This brings every phase of the bit divider and every small reload period within reach, and the expected strobe cycles are computed as multiples of N+1. Lower-byte writes are issued while a count is in progress, which exercises the immediate-reload path. An upper-byte write placed mid-count shows the staged value taking effect only at the next natural reload.

// File: rtl/baud_pkg.sv
// Shared constants and types for the bit-rate prescaler.
// Assumes the normal oversample factor is a power of two and that
// double-speed mode uses half of it.
package baud_pkg;
    localparam int unsigned OS_NORMAL = 16;
    localparam int unsigned OS_DOUBLE = OS_NORMAL / 2;
    localparam int unsigned PH_W      = $clog2(OS_NORMAL);

    typedef enum logic {
        SPEED_NORMAL = 1'b0,
        SPEED_DOUBLE = 1'b1
    } speed_e;
endpackage

// File: rtl/baud_div_regs.sv
// Divisor storage: an upper and a lower byte register.
// Assumes DIV_W > BUS_W. Upper bits above DIV_W-BUS_W are reserved:
// they are discarded on write and read back as zero.
module baud_div_regs #(
    parameter int unsigned DIV_W = 12,
    parameter int unsigned BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hi_we,
    input  logic             lo_we,
    input  logic [BUS_W-1:0] wdata,
    output logic [DIV_W-1:0] div_q,
    output logic [DIV_W-1:0] load_val,
    output logic [BUS_W-1:0] hi_rdata,
    output logic [BUS_W-1:0] lo_rdata
);
    localparam int unsigned HI_W = DIV_W - BUS_W;

    logic [HI_W-1:0]  hi_q;
    logic [BUS_W-1:0] lo_q;

    // Capture byte writes; only the implemented upper bits are kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (hi_we) hi_q <= wdata[HI_W-1:0];
            if (lo_we) lo_q <= wdata;
        end
    end

    // Present the stored divisor and the value an immediate reload uses.
    always_comb begin
        div_q    = {hi_q, lo_q};
        load_val = {hi_q, wdata};
        hi_rdata = {{(BUS_W-HI_W){1'b0}}, hi_q};
        lo_rdata = lo_q;
    end

    // R2: reserved upper readback bits never read as one
    p_resv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hi_rdata[BUS_W-1:HI_W] == '0);

    // R5: an upper-byte write leaves the lower byte untouched
    p_hi_keeps_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_we && !lo_we) |=> lo_q == $past(lo_q));
endmodule

// File: rtl/baud_os_counter.sv
// Oversample down-counter. Reloads from the stored divisor at zero and
// raises a one-cycle strobe on that reload. A lower-byte write forces
// an immediate load without a strobe. Assumes the divisor is stable
// between writes.
module baud_os_counter #(
    parameter int unsigned DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_load,
    input  logic [DIV_W-1:0] load_val,
    input  logic [DIV_W-1:0] div_q,
    input  logic             hi_we,
    output logic             os_tick
);
    logic [DIV_W-1:0] cnt;

    // Count down, reload at zero, and honour forced loads first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            os_tick <= 1'b0;
        end else if (force_load) begin
            cnt     <= load_val;
            os_tick <= 1'b0;
        end else if (cnt == '0) begin
            cnt     <= div_q;
            os_tick <= 1'b1;
        end else begin
            cnt     <= cnt - 1'b1;
            os_tick <= 1'b0;
        end
    end

    // R3: a forced load takes the written value and suppresses the strobe
    p_force_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        force_load |=> (cnt == $past(load_val)) && !os_tick);

    // R4: between reloads the count steps by one without a strobe
    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1) && !os_tick);

    // R5: an upper-byte write alone does not disturb the running count
    p_stage_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_we && !force_load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/baud_bit_divider.sv
// Divides the oversample strobe by 16 (normal) or 8 (double speed).
// A restart clears the phase so the bit period lines up with a fresh
// divisor load. Assumes the mode is changed only between frames.
module baud_bit_divider
    import baud_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   restart,
    input  logic   os_tick,
    input  speed_e speed,
    output logic   bit_tick
);
    logic [PH_W-1:0] phase;
    logic            at_last;

    // Last phase: all bits set, or only the lower bits in double speed.
    always_comb begin
        if (speed == SPEED_DOUBLE) at_last = &phase[PH_W-2:0];
        else                       at_last = &phase;
    end

    // Advance the phase on each oversample strobe; strobe on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase    <= '0;
            bit_tick <= 1'b0;
        end else if (os_tick) begin
            phase    <= phase + 1'b1;
            bit_tick <= at_last;
        end else begin
            bit_tick <= 1'b0;
        end
    end

    // R6: a bit strobe is always preceded by an oversample strobe
    p_bit_follows_os_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> $past(os_tick));

    // R7: in double speed a bit strobe leaves the lower phase bits at zero
    p_double_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && speed == SPEED_DOUBLE) |-> phase[PH_W-2:0] == '0);
endmodule

// File: rtl/baud_prescaler.sv
// Top level of the bit-rate prescaler: divisor registers, oversample
// counter and bit divider. A lower-byte write restarts both stages.
module baud_prescaler
    import baud_pkg::*;
#(
    parameter int unsigned DIV_W = 12,
    parameter int unsigned BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hi_we,
    input  logic             lo_we,
    input  logic [BUS_W-1:0] wdata,
    input  logic             dbl_speed,
    output logic [BUS_W-1:0] hi_rdata,
    output logic [BUS_W-1:0] lo_rdata,
    output logic             os_tick,
    output logic             bit_tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] load_val;
    speed_e           speed;

    // Map the mode pin onto the shared speed type.
    always_comb speed = dbl_speed ? SPEED_DOUBLE : SPEED_NORMAL;

    baud_div_regs #(.DIV_W(DIV_W), .BUS_W(BUS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .hi_we(hi_we), .lo_we(lo_we),
        .wdata(wdata), .div_q(div_q), .load_val(load_val),
        .hi_rdata(hi_rdata), .lo_rdata(lo_rdata)
    );

    baud_os_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .force_load(lo_we), .load_val(load_val),
        .div_q(div_q), .hi_we(hi_we), .os_tick(os_tick)
    );

    baud_bit_divider u_bit (
        .clk(clk), .rst_n(rst_n), .restart(lo_we), .os_tick(os_tick),
        .speed(speed), .bit_tick(bit_tick)
    );

    // R3: no strobe in the cycle after a lower-byte write
    p_quiet_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lo_we |=> !os_tick && !bit_tick);
endmodule

// File: tb/tb_baud_prescaler.sv
module tb_baud_prescaler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hi_we = 1'b0;
    logic       lo_we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       dbl_speed = 1'b0;
    logic [7:0] hi_rdata, lo_rdata;
    logic       os_tick, bit_tick;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    baud_prescaler dut (
        .clk(clk), .rst_n(rst_n), .hi_we(hi_we), .lo_we(lo_we),
        .wdata(wdata), .dbl_speed(dbl_speed), .hi_rdata(hi_rdata),
        .lo_rdata(lo_rdata), .os_tick(os_tick), .bit_tick(bit_tick)
    );

    task automatic check(input string req, input int act, input int exp, input int k);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at k=%0d: actual=%0d expected=%0d", req, k, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Write the upper byte (staged only).
    task automatic write_hi(input logic [7:0] v);
        @(negedge clk); hi_we = 1'b1; wdata = v;
        @(negedge clk); hi_we = 1'b0;
    endtask

    // Write the lower byte; returns after the write edge (k = 0).
    task automatic write_lo(input logic [7:0] v);
        @(negedge clk); lo_we = 1'b1; wdata = v;
        @(posedge clk);
        @(negedge clk); lo_we = 1'b0;
    endtask

    // Load divisor n, then check both strobes for every cycle of two bit periods.
    task automatic run_case(input int n, input bit dbl, input string rq);
        int m;
        int per;
        m = dbl ? 8 : 16;
        per = n + 1;
        dbl_speed = dbl;
        write_hi(8'((n >> 8) & 15));
        write_lo(8'(n & 255));
        check("R3", {31'd0, os_tick}, 0, 0);
        check("R3", {31'd0, bit_tick}, 0, 0);
        for (int k = 1; k <= 2 * m * per + 2; k++) begin
            @(negedge clk);
            check(n == 0 ? "R8" : "R4", {31'd0, os_tick}, (k % per == 0) ? 1 : 0, k);
            check(rq, {31'd0, bit_tick}, (k > 1 && ((k - 1) % (m * per)) == 0) ? 1 : 0, k);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {31'd0, os_tick}, 0, 0);
        check("R1", {31'd0, bit_tick}, 0, 0);
        check("R1", {24'd0, hi_rdata}, 0, 0);
        check("R1", {24'd0, lo_rdata}, 0, 0);
        rst_n = 1'b1;

        // R2: reserved bits read as zero
        write_hi(8'hF5);
        check("R2", {24'd0, hi_rdata}, 5, 0);
        write_hi(8'h0A);
        check("R2", {24'd0, hi_rdata}, 10, 0);
        write_lo(8'hC3);
        check("R3", {24'd0, lo_rdata}, 8'hC3, 0);

        // R4/R6/R7/R8: sweep small divisors in both modes
        for (int n = 0; n < 16; n++) run_case(n, 1'b0, "R6");
        for (int n = 0; n < 16; n++) run_case(n, 1'b1, "R7");
        run_case(12'h123, 1'b0, "R6");

        // R5: upper write mid-count takes effect only at the natural reload
        dbl_speed = 1'b0;
        write_hi(8'h00);
        write_lo(8'h02);                // k = 0, N = 2
        @(negedge clk);                 // k = 1
        hi_we = 1'b1; wdata = 8'h01;    // sampled at k = 2
        @(negedge clk); hi_we = 1'b0;   // k = 2
        check("R5", {31'd0, os_tick}, 0, 2);
        for (int k = 3; k <= 265; k++) begin
            @(negedge clk);
            check("R5", {31'd0, os_tick}, (k == 3 || k == 262) ? 1 : 0, k);
        end

        // R3: lower write applies the staged upper bits immediately (N = 0x102)
        write_lo(8'h02);
        for (int k = 1; k <= 260; k++) begin
            @(negedge clk);
            check("R3", {31'd0, os_tick}, (k == 259) ? 1 : 0, k);
        end
        check("R2", {24'd0, hi_rdata}, 1, 0);

        finish_run();
    end
endmodule